// File: doc/BRIEF.md
# Dual-Mode Timer Channel

A single counter channel, up to 32 bits wide, paired with one load register. In generate mode the counter starts from a value copied out of the load register. It steps once per enabled clock and flags every wrap-around. On a wrap it either reloads the stored value and keeps running, or freezes. Each wrap can produce a one-clock pulse on a generate output whose active level is a parameter. In capture mode the same counter runs freely. On an edge of an external capture input it copies its current value into the load register, which gives a time tag for the event.

A single reload/hold control serves both modes. In generate mode it chooses between auto-reload and freeze. In capture mode it chooses between overwriting on every capture and keeping the first capture until the load register is read. Every wrap or capture also raises a one-clock event strobe for an interrupt controller. There is no prescaler; the channel steps at the clock rate. Address decoding happens outside the channel, which sees only write and read strobes for its load register.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count and the load register are zero, the event strobe is low, and the generate output sits at its inactive level.
- R2: A write strobe stores the write data in the load register and leaves the count unchanged. A high load control copies the load register into the count at the next clock edge.
- R3: While enabled and not frozen, the count steps by one per clock. It counts up when the direction input is 0 and down when it is 1.
- R4: In generate mode (mode input 0), a wrap happens when the count steps from all ones to zero (up) or from zero to all ones (down). With reload/hold set, the wrapped value is shown for one clock and the stored value is then reloaded. The repeat interval is therefore load+2 clocks when counting down and MAX−load+2 clocks when counting up.
- R5: In generate mode with reload/hold clear, the count freezes at its wrapped value until the next load.
- R6: When the generate-output enable is high, each generate-mode wrap drives the generate output to its active level for exactly one clock. That clock is the cycle in which the count shows the wrapped value. With the enable low, the output stays inactive.
- R7: The event strobe is high for one clock after each generate-mode wrap and after each capture event.
- R8: In capture mode (mode input 1) with capture enable high, the raw capture input passes through two synchronizing flops. A capture event is the synchronized level changing into the active level. The load register then takes the count of the cycle that follows the second clock edge after the input changes, and it updates at the third edge.
- R9: With reload/hold set, every capture overwrites the load register. With it clear, the first capture is kept and later captures are dropped until a read strobe. A read strobe re-arms capturing.
- R10: While the enable input is low, or in capture mode with capture enable low, no wrap or capture event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| mode_i | input | 1 | 0 generate, 1 capture |
| dir_i | input | 1 | 0 count up, 1 count down |
| arh_i | input | 1 | Reload/hold: 1 reload or overwrite, 0 hold |
| load_i | input | 1 | Copy load register into count |
| gen_en_i | input | 1 | Generate output enable |
| cap_en_i | input | 1 | Capture enable |
| wr_i | input | 1 | Load register write strobe |
| wdata_i | input | CNT_W | Load register write data |
| rd_i | input | 1 | Load register read strobe |
| cap_raw_i | input | 1 | Asynchronous capture input |
| cnt_o | output | CNT_W | Current count |
| load_o | output | CNT_W | Load register value |
| gen_o | output | 1 | Generate pulse, level set by GEN_ACTIVE |
| evt_o | output | 1 | One-clock event strobe |

## Verification
The count and the load register change at the first edge after a load, write or enabled step. The generate pulse and the event strobe show up in the same cycle as the wrapped count. A capture lands on the third edge after the raw input changes. The bench drives and samples on the falling edge and waits exactly that many rising edges before each comparison. For capture, it records the count at the falling edge after the second rising edge and expects that value in the load register after the third. Generate intervals are measured as the number of falling edges between two successive pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {TMR_GEN = 1'b0, TMR_CAP = 1'b1} tmr_mode_e;
endpackage

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge #(
  parameter bit ACTIVE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic edge_o
);
  localparam logic IDLE = ~ACTIVE;
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = (s2_q == ACTIVE) && (s3_q != ACTIVE);
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  tmr_mode_e        mode_i,
  input  logic             dir_i,
  input  logic             arh_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q;
  logic roll_q, held_q;
  logic is_gen, reload_now, step, at_end, wrap;

  always_comb begin
    is_gen     = (mode_i == TMR_GEN);
    reload_now = roll_q && arh_i && en_i && is_gen;
    step       = en_i && !load_i && !reload_now && !(held_q && is_gen);
    at_end     = dir_i ? (cnt_q == '0) : (cnt_q == '1);
    wrap       = step && at_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      roll_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      if (load_i || reload_now) cnt_q <= load_val_i;
      else if (step)            cnt_q <= dir_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
      roll_q <= wrap && is_gen;
      if (load_i || reload_now || !is_gen) held_q <= 1'b0;
      else if (wrap && !arh_i)             held_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign roll_o = roll_q;
endmodule

// File: rtl/tmr_load_reg.sv
module tmr_load_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             rd_i,
  input  logic             cap_i,
  input  logic             arh_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] load_o
);
  logic [CNT_W-1:0] load_q;
  logic kept_q;
  logic take;

  assign take = cap_i && !wr_i && (arh_i || !kept_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      kept_q <= 1'b0;
    end else begin
      if (wr_i)      load_q <= wdata_i;
      else if (take) load_q <= cnt_i;
      if (rd_i)      kept_q <= 1'b0;
      else if (take) kept_q <= 1'b1;
    end
  end

  assign load_o = load_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter bit GEN_ACTIVE = 1'b1,
  parameter bit CAP_ACTIVE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             dir_i,
  input  logic             arh_i,
  input  logic             load_i,
  input  logic             gen_en_i,
  input  logic             cap_en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             rd_i,
  input  logic             cap_raw_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic             gen_o,
  output logic             evt_o
);
  tmr_mode_e        mode;
  logic [CNT_W-1:0] cnt, load_val;
  logic roll, cap_edge, cap_evt, cap_q;

  assign mode = tmr_mode_e'(mode_i);

  tmr_cap_edge #(.ACTIVE(CAP_ACTIVE)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(cap_raw_i), .edge_o(cap_edge)
  );

  assign cap_evt = cap_edge && en_i && cap_en_i && (mode == TMR_CAP);

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode), .dir_i(dir_i),
    .arh_i(arh_i), .load_i(load_i), .load_val_i(load_val),
    .cnt_o(cnt), .roll_o(roll)
  );

  tmr_load_reg #(.CNT_W(CNT_W)) u_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .cap_i(cap_evt), .arh_i(arh_i), .cnt_i(cnt), .load_o(load_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_evt;
  end

  generate
    if (GEN_ACTIVE) begin : g_gen_hi
      assign gen_o = roll && gen_en_i;
    end else begin : g_gen_lo
      assign gen_o = !(roll && gen_en_i);
    end
  endgenerate

  assign evt_o  = roll || cap_q;
  assign cnt_o  = cnt;
  assign load_o = load_val;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W      = 32,
  parameter bit GEN_ACTIVE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             mode_i,
  input logic             arh_i,
  input logic             load_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] load_o,
  input logic             gen_o,
  input logic             evt_o
);
  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_o)); // R2
  AST_RELOAD_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !$past(mode_i) && !mode_i && arh_i && en_i && !load_i)
      |=> cnt_o == $past(load_o)); // R4
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !$past(mode_i) && !mode_i && !$past(arh_i) && !arh_i && !load_i)
      |=> $stable(cnt_o)); // R5
  AST_GEN_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_o == GEN_ACTIVE) |=> (gen_o != GEN_ACTIVE)); // R6
  AST_NO_EVT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !evt_o); // R10
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .GEN_ACTIVE(GEN_ACTIVE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .arh_i(arh_i),
  .load_i(load_i), .cnt_o(cnt_o), .load_o(load_o), .gen_o(gen_o), .evt_o(evt_o)
);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, mode = 0, dir = 0, arh = 0, load = 0, gen_en = 0, cap_en = 0;
  logic wr = 0, rd = 0, cap_raw = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt, ldv;
  logic gen, evt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_channel #(.CNT_W(W), .GEN_ACTIVE(1'b1), .CAP_ACTIVE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .dir_i(dir), .arh_i(arh),
    .load_i(load), .gen_en_i(gen_en), .cap_en_i(cap_en), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .cap_raw_i(cap_raw), .cnt_o(cnt), .load_o(ldv), .gen_o(gen), .evt_o(evt)
  );

  // {dir, load value, expected interval}
  localparam logic [24:0] VEC [6] = '{
    {1'b1, 8'd3,   16'd5},
    {1'b1, 8'd0,   16'd2},
    {1'b1, 8'd10,  16'd12},
    {1'b0, 8'd250, 16'd7},
    {1'b0, 8'd255, 16'd2},
    {1'b0, 8'd200, 16'd57}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_load(input logic [W-1:0] v);
    wr = 1; wdata = v; ticks(1); wr = 0;
  endtask

  task automatic do_load();
    load = 1; ticks(1); load = 0;
  endtask

  task automatic capture_pulse(output logic [W-1:0] seen);
    cap_raw = 1; ticks(2); seen = cnt; ticks(1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c1, c2;
    int gap, pulses, guard;
    ticks(2);
    check("R1 count", cnt, 0); check("R1 load", ldv, 0);
    check("R1 gen", gen, 0);   check("R1 evt", evt, 0);
    rst_n = 1; ticks(1);

    // R2: write leaves count, load copies
    write_load(8'h20);
    check("R2 write", ldv, 8'h20); check("R2 count untouched", cnt, 0);
    do_load(); check("R2 load", cnt, 8'h20);
    // R3 up then down
    en = 1; dir = 0; ticks(3); check("R3 up", cnt, 8'h23);
    dir = 1; ticks(2); check("R3 down", cnt, 8'h21);
    en = 0; ticks(2); check("R10 disabled holds", cnt, 8'h21);

    // R4/R6 interval vectors
    gen_en = 1; arh = 1; mode = 0;
    foreach (VEC[k]) begin
      en = 0; dir = VEC[k][24]; write_load(VEC[k][23:16]); do_load();
      check("R2 vector load", cnt, VEC[k][23:16]);
      en = 1;
      guard = 0;
      while (!gen && guard < 600) begin ticks(1); guard++; end
      check("R4 wrap value", cnt, dir ? MAXV : 0);
      check("R7 evt with wrap", evt, 1);
      ticks(1); check("R6 one clock", gen, 0);
      gap = 1;
      while (!gen && gap < 600) begin ticks(1); gap++; end
      check("R4 interval", gap, VEC[k][15:0]);
    end

    // R5 hold, R6 gate
    en = 0; arh = 0; dir = 1; gen_en = 0; write_load(8'd2); do_load(); en = 1;
    ticks(3);
    check("R5 wrap", cnt, MAXV); check("R7 evt", evt, 1); check("R6 gated", gen, 0);
    ticks(4);
    check("R5 frozen", cnt, MAXV); check("R7 single", evt, 0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin ticks(1); if (evt) pulses++; end
    check("R5 no more events", pulses, 0);

    // R10 disabled at boundary
    en = 0; write_load(8'd0); do_load();
    pulses = 0;
    for (int i = 0; i < 10; i++) begin ticks(1); if (evt) pulses++; end
    check("R10 no evt while off", pulses, 0); check("R10 count still", cnt, 0);

    // capture
    mode = 1; cap_en = 1; dir = 0; arh = 0; en = 1; ticks(5);
    capture_pulse(c1);
    check("R8 captured", ldv, c1); check("R7 capture evt", evt, 1);
    ticks(1); check("R7 capture one clock", evt, 0);
    cap_raw = 0; ticks(4);
    capture_pulse(c2);
    check("R9 held value", ldv, c1);
    cap_raw = 0; rd = 1; ticks(1); rd = 0; ticks(3);
    capture_pulse(c2);
    check("R9 rearmed", ldv, c2);
    arh = 1; cap_raw = 0; ticks(3);
    capture_pulse(c1); check("R9 overwrite 1", ldv, c1);
    cap_raw = 0; ticks(5);
    capture_pulse(c2); check("R9 overwrite 2", ldv, c2);
    // R10 capture disabled
    cap_raw = 0; cap_en = 0; ticks(3); c1 = ldv;
    cap_raw = 1; ticks(4);
    check("R10 cap_en off", ldv, c1); check("R10 no cap evt", evt, 0);
    cap_raw = 0; cap_en = 1; en = 0; ticks(3);
    cap_raw = 1; ticks(4);
    check("R10 disabled capture", ldv, c1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule